// File: doc/BRIEF.md
# Issue Stall Accounting Monitor

This block watches the issue stream of an in-order core that retires instructions singly or as parallel pairs, and estimates the pipeline bubbles the stream would cost. It does not stall anything. It only counts. It keeps a scoreboard of general registers whose load data is still on its way. Every issued instruction presents a unit code, up to two source operands (each with its own valid flag), a destination index, a taken flag and a base cycle cost.

A load marks its destination as pending. When the instruction group that holds the load ends, the pending set becomes the active set for exactly one following group. A source operand that the unit type actually reads and that hits the active set adds a fixed load-use penalty. Taken control transfers add a fixed redirect penalty. Taken and untaken transfers are counted apart. A group total adds the base costs and penalties of all instructions in a group, and it is posted to the total counter only when the last instruction of the group issues. Every counter saturates. A synchronous reset or a clear strobe zeroes the counters.

Top module: `issue_stall_monitor`

## Requirements
- R1: After reset, all five counters read 0. While `clr_i` is high, every counter reads 0 on the next cycle, even if an instruction issues in the same cycle.
- R2: A load (unit code 3) marks `dst_idx_i` pending. A source that issues in the same group as the load never stalls on it. A source in the very next group stalls on it.
- R3: Each checked, valid source whose index is in the active set adds 2 to `load_stall_o`. Two such sources in one instruction add 4.
- R4: A source whose valid flag is 0 never adds to `load_stall_o`, whatever its index.
- R5: Unit codes 0 (execute) and 1 (compare) check sources A and B. Code 2 (control transfer) checks source A only. Codes 3 (load), 4 (store) and 5 to 7 check no sources.
- R6: A code-2 instruction with `taken_i`=1 adds 2 to `ctrl_stall_o` and 1 to `taken_cnt_o`. With `taken_i`=0 it adds 1 to `untaken_cnt_o` only. For other unit codes, `taken_i` has no effect.
- R7: The active set lasts one group. A register loaded two groups earlier no longer stalls unless it is loaded again.
- R8: `total_cyc_o` changes only when an instruction with `iss_last_i`=1 issues. It then grows by the sum, over the group, of `iss_cycles_i` plus the load-use and control-transfer penalties. `iss_first_i` starts a fresh group sum.
- R9: Every counter stops at 2^CNT_W-1 and holds there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Counter clear strobe |
| iss_valid_i | input | 1 | An instruction issues this cycle |
| iss_unit_i | input | 3 | Unit code of the instruction |
| iss_first_i | input | 1 | First instruction of its group |
| iss_last_i | input | 1 | Last instruction of its group |
| iss_cycles_i | input | CYC_W | Base cycle cost of the instruction |
| src_a_vld_i | input | 1 | Source A present |
| src_a_idx_i | input | 4 | Source A register index |
| src_b_vld_i | input | 1 | Source B present |
| src_b_idx_i | input | 4 | Source B register index |
| dst_idx_i | input | 4 | Destination register index |
| taken_i | input | 1 | Control transfer taken |
| load_stall_o | output | CNT_W | Load-use stall cycles |
| ctrl_stall_o | output | CNT_W | Control-transfer stall cycles |
| taken_cnt_o | output | CNT_W | Taken transfer count |
| untaken_cnt_o | output | CNT_W | Untaken transfer count |
| total_cyc_o | output | CNT_W | Accumulated group cycle total |

## Verification
The bound checker covers the rules that hold on every cycle:
- a clear zeroes the counters;
- an instruction with no valid sources or a store leaves the stall counters alone;
- an untaken transfer moves neither redirect counter, and a taken one bumps the taken count by one;
- the total moves only on the last instruction of a group;
- a counter at its ceiling stays there.

Only the directed scenarios can show the one-group lifetime of a load's mark, the lack of a stall inside the load's own group, the per-unit operand selection, the exact group sums, and the saturation values reached after long runs.

// File: rtl/stall_mon_pkg.sv
`timescale 1ns/1ps
package stall_mon_pkg;

    localparam int unsigned REG_IDX_W = 4;
    localparam int unsigned NREGS     = 1 << REG_IDX_W;

    typedef enum logic [2:0] {
        U_EXEC  = 3'd0,
        U_CMP   = 3'd1,
        U_CTI   = 3'd2,
        U_LOAD  = 3'd3,
        U_STORE = 3'd4
    } unit_e;

    typedef struct packed {
        logic                 vld;
        logic [REG_IDX_W-1:0] idx;
    } src_t;

    // bit 0: source A is read, bit 1: source B is read
    function automatic logic [1:0] src_checks(input logic [2:0] unit);
        case (unit)
            U_EXEC, U_CMP: src_checks = 2'b11;
            U_CTI:         src_checks = 2'b01;
            default:       src_checks = 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/stall_sat_counter.sv
`timescale 1ns/1ps
module stall_sat_counter #(
    parameter int unsigned W     = 32,
    parameter int unsigned AMT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic [W-1:0]     cnt_o
);
    localparam int unsigned SUM_W = W + 1;

    logic [SUM_W-1:0] sum;

    assign sum = {1'b0, cnt_o} + SUM_W'(amt_i);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_o <= '0;
        end else if (sum[W]) begin
            cnt_o <= '1;
        end else begin
            cnt_o <= sum[W-1:0];
        end
    end
endmodule

// File: rtl/stall_scoreboard.sv
`timescale 1ns/1ps
module stall_scoreboard
    import stall_mon_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 boundary_i,
    input  logic                 load_i,
    input  logic [REG_IDX_W-1:0] load_idx_i,
    output logic [NREGS-1:0]     active_o
);
    logic [NREGS-1:0] pending_q;
    logic [NREGS-1:0] pending_nx;

    always_comb begin
        pending_nx = pending_q;
        if (load_i) begin
            pending_nx[load_idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= '0;
            active_o  <= '0;
        end else if (boundary_i) begin
            active_o  <= pending_nx;
            pending_q <= '0;
        end else begin
            pending_q <= pending_nx;
        end
    end
endmodule

// File: rtl/stall_penalty.sv
`timescale 1ns/1ps
module stall_penalty
    import stall_mon_pkg::*;
#(
    parameter int unsigned PEN_W    = 8,
    parameter int unsigned LOAD_PEN = 2,
    parameter int unsigned CTI_PEN  = 2
) (
    input  logic             valid_i,
    input  logic [2:0]       unit_i,
    input  src_t             src_a_i,
    input  src_t             src_b_i,
    input  logic             taken_i,
    input  logic [NREGS-1:0] active_i,
    output logic [PEN_W-1:0] load_add_o,
    output logic [PEN_W-1:0] cti_add_o,
    output logic             is_taken_o,
    output logic             is_untaken_o
);
    localparam int unsigned NSRC = 2;

    src_t             srcs [NSRC];
    logic [NSRC-1:0]  chk;
    logic [NSRC-1:0]  hit;
    logic [PEN_W-1:0] nhit;
    logic             is_cti;

    assign srcs[0] = src_a_i;
    assign srcs[1] = src_b_i;
    assign chk     = src_checks(unit_i);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign hit[i] = valid_i & chk[i] & srcs[i].vld & active_i[srcs[i].idx];
    end

    assign nhit       = PEN_W'(hit[0]) + PEN_W'(hit[1]);
    assign load_add_o = nhit * PEN_W'(LOAD_PEN);

    assign is_cti       = valid_i && (unit_i == U_CTI);
    assign is_taken_o   = is_cti & taken_i;
    assign is_untaken_o = is_cti & ~taken_i;
    assign cti_add_o    = is_taken_o ? PEN_W'(CTI_PEN) : '0;
endmodule

// File: rtl/issue_stall_monitor.sv
`timescale 1ns/1ps
module issue_stall_monitor
    import stall_mon_pkg::*;
#(
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned CYC_W    = 4,
    parameter int unsigned PEN_W    = 8,
    parameter int unsigned LOAD_PEN = 2,
    parameter int unsigned CTI_PEN  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr_i,
    input  logic                 iss_valid_i,
    input  logic [2:0]           iss_unit_i,
    input  logic                 iss_first_i,
    input  logic                 iss_last_i,
    input  logic [CYC_W-1:0]     iss_cycles_i,
    input  logic                 src_a_vld_i,
    input  logic [REG_IDX_W-1:0] src_a_idx_i,
    input  logic                 src_b_vld_i,
    input  logic [REG_IDX_W-1:0] src_b_idx_i,
    input  logic [REG_IDX_W-1:0] dst_idx_i,
    input  logic                 taken_i,
    output logic [CNT_W-1:0]     load_stall_o,
    output logic [CNT_W-1:0]     ctrl_stall_o,
    output logic [CNT_W-1:0]     taken_cnt_o,
    output logic [CNT_W-1:0]     untaken_cnt_o,
    output logic [CNT_W-1:0]     total_cyc_o
);
    localparam int unsigned GS_W = CNT_W + 2;

    src_t             src_a, src_b;
    logic [NREGS-1:0] active;
    logic [PEN_W-1:0] load_add, cti_add;
    logic             is_taken, is_untaken;
    logic             boundary, is_load;
    logic [CNT_W-1:0] grp_acc_q, grp_base, grp_now, total_amt;
    logic [GS_W-1:0]  grp_sum;

    assign src_a    = '{vld: src_a_vld_i, idx: src_a_idx_i};
    assign src_b    = '{vld: src_b_vld_i, idx: src_b_idx_i};
    assign boundary = iss_valid_i & iss_last_i;
    assign is_load  = iss_valid_i && (iss_unit_i == U_LOAD);

    stall_scoreboard u_sb (
        .clk        (clk),
        .rst        (rst),
        .boundary_i (boundary),
        .load_i     (is_load),
        .load_idx_i (dst_idx_i),
        .active_o   (active)
    );

    stall_penalty #(
        .PEN_W    (PEN_W),
        .LOAD_PEN (LOAD_PEN),
        .CTI_PEN  (CTI_PEN)
    ) u_pen (
        .valid_i      (iss_valid_i),
        .unit_i       (iss_unit_i),
        .src_a_i      (src_a),
        .src_b_i      (src_b),
        .taken_i      (taken_i),
        .active_i     (active),
        .load_add_o   (load_add),
        .cti_add_o    (cti_add),
        .is_taken_o   (is_taken),
        .is_untaken_o (is_untaken)
    );

    // group cost: a first instruction starts from zero
    assign grp_base = iss_first_i ? '0 : grp_acc_q;
    assign grp_sum  = GS_W'(grp_base) + GS_W'(iss_cycles_i)
                    + GS_W'(load_add) + GS_W'(cti_add);
    assign grp_now  = (|grp_sum[GS_W-1:CNT_W]) ? '1 : grp_sum[CNT_W-1:0];
    assign total_amt = boundary ? grp_now : '0;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            grp_acc_q <= '0;
        end else if (iss_valid_i) begin
            grp_acc_q <= iss_last_i ? '0 : grp_now;
        end
    end

    stall_sat_counter #(.W(CNT_W), .AMT_W(PEN_W)) u_ld_cnt (
        .clk(clk), .rst(rst), .clr_i(clr_i), .amt_i(load_add), .cnt_o(load_stall_o));

    stall_sat_counter #(.W(CNT_W), .AMT_W(PEN_W)) u_cti_cnt (
        .clk(clk), .rst(rst), .clr_i(clr_i), .amt_i(cti_add), .cnt_o(ctrl_stall_o));

    stall_sat_counter #(.W(CNT_W), .AMT_W(1)) u_tk_cnt (
        .clk(clk), .rst(rst), .clr_i(clr_i), .amt_i(is_taken), .cnt_o(taken_cnt_o));

    stall_sat_counter #(.W(CNT_W), .AMT_W(1)) u_ut_cnt (
        .clk(clk), .rst(rst), .clr_i(clr_i), .amt_i(is_untaken), .cnt_o(untaken_cnt_o));

    stall_sat_counter #(.W(CNT_W), .AMT_W(CNT_W)) u_tot_cnt (
        .clk(clk), .rst(rst), .clr_i(clr_i), .amt_i(total_amt), .cnt_o(total_cyc_o));
endmodule

// File: rtl/issue_stall_monitor_chk.sv
`timescale 1ns/1ps
module issue_stall_monitor_chk #(
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned LOAD_PEN = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_i,
    input logic             iss_valid_i,
    input logic [2:0]       iss_unit_i,
    input logic             iss_last_i,
    input logic             src_a_vld_i,
    input logic             src_b_vld_i,
    input logic             taken_i,
    input logic [CNT_W-1:0] load_stall_o,
    input logic [CNT_W-1:0] ctrl_stall_o,
    input logic [CNT_W-1:0] taken_cnt_o,
    input logic [CNT_W-1:0] untaken_cnt_o,
    input logic [CNT_W-1:0] total_cyc_o
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    a_r1_clear: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (load_stall_o == '0) && (ctrl_stall_o == '0) && (taken_cnt_o == '0)
                  && (untaken_cnt_o == '0) && (total_cyc_o == '0));

    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> (load_stall_o >= $past(load_stall_o))
                   && ((load_stall_o - $past(load_stall_o)) <= CNT_W'(2 * LOAD_PEN)));

    a_r4_no_operand: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !src_a_vld_i && !src_b_vld_i) |=> $stable(load_stall_o));

    a_r5_store_quiet: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && iss_valid_i && iss_unit_i == 3'd4)
        |=> $stable(load_stall_o) && $stable(ctrl_stall_o)
            && $stable(taken_cnt_o) && $stable(untaken_cnt_o));

    a_r6_untaken: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && iss_valid_i && iss_unit_i == 3'd2 && !taken_i)
        |=> $stable(ctrl_stall_o) && $stable(taken_cnt_o));

    a_r6_taken_step: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && iss_valid_i && iss_unit_i == 3'd2 && taken_i && taken_cnt_o != MAXV)
        |=> taken_cnt_o == $past(taken_cnt_o) + 1'b1);

    a_r8_total_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !(iss_valid_i && iss_last_i)) |=> $stable(total_cyc_o));

    a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && untaken_cnt_o == MAXV) |=> untaken_cnt_o == MAXV);
endmodule

bind issue_stall_monitor issue_stall_monitor_chk #(
    .CNT_W    (CNT_W),
    .LOAD_PEN (LOAD_PEN)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .clr_i         (clr_i),
    .iss_valid_i   (iss_valid_i),
    .iss_unit_i    (iss_unit_i),
    .iss_last_i    (iss_last_i),
    .src_a_vld_i   (src_a_vld_i),
    .src_b_vld_i   (src_b_vld_i),
    .taken_i       (taken_i),
    .load_stall_o  (load_stall_o),
    .ctrl_stall_o  (ctrl_stall_o),
    .taken_cnt_o   (taken_cnt_o),
    .untaken_cnt_o (untaken_cnt_o),
    .total_cyc_o   (total_cyc_o)
);

// File: tb/issue_stall_monitor_tb_top.sv
`timescale 1ns/1ps
module issue_stall_monitor_tb_top;
    localparam int unsigned CNT_W = 8;
    localparam int unsigned CYC_W = 4;

    localparam int EXEC = 0, CMP = 1, CTI = 2, LOAD = 3, STORE = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic vld = 1'b0;
    logic [2:0] unit = '0;
    logic first = 1'b0, last = 1'b0;
    logic [CYC_W-1:0] cyc = '0;
    logic av = 1'b0, bv = 1'b0, tk = 1'b0;
    logic [3:0] ai = '0, bi = '0, dst = '0;
    logic [CNT_W-1:0] ld_o, cti_o, tk_o, ut_o, tot_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    issue_stall_monitor #(.CNT_W(CNT_W), .CYC_W(CYC_W)) dut_i (
        .clk(clk), .rst(rst), .clr_i(clr), .iss_valid_i(vld), .iss_unit_i(unit),
        .iss_first_i(first), .iss_last_i(last), .iss_cycles_i(cyc),
        .src_a_vld_i(av), .src_a_idx_i(ai), .src_b_vld_i(bv), .src_b_idx_i(bi),
        .dst_idx_i(dst), .taken_i(tk),
        .load_stall_o(ld_o), .ctrl_stall_o(cti_o), .taken_cnt_o(tk_o),
        .untaken_cnt_o(ut_o), .total_cyc_o(tot_o));

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // drive one instruction for one cycle, called and returning at a negedge
    task automatic issue(input int u, input bit f, input bit l, input int c,
                         input bit a_v, input int a_i, input bit b_v, input int b_i,
                         input int d, input bit t);
        vld = 1'b1; unit = 3'(u); first = f; last = l; cyc = CYC_W'(c);
        av = a_v; ai = 4'(a_i); bv = b_v; bi = 4'(b_i); dst = 4'(d); tk = t;
        @(negedge clk);
        vld = 1'b0; av = 1'b0; bv = 1'b0; tk = 1'b0;
    endtask

    task automatic single(input int u, input int c, input bit a_v, input int a_i,
                          input bit b_v, input int b_i, input int d, input bit t);
        issue(u, 1'b1, 1'b1, c, a_v, a_i, b_v, b_i, d, t);
    endtask

    task automatic fresh();
        single(EXEC, 0, 0, 0, 0, 0, 0, 0);
        single(EXEC, 0, 0, 0, 0, 0, 0, 0);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "load_stall after reset", int'(ld_o), 0);
        check("R1", "ctrl_stall after reset", int'(cti_o), 0);
        check("R1", "taken after reset", int'(tk_o), 0);
        check("R1", "untaken after reset", int'(ut_o), 0);
        check("R1", "total after reset", int'(tot_o), 0);
    endtask

    task automatic t_load_use();
        fresh();
        single(LOAD, 1, 0, 0, 0, 0, 3, 0);
        single(EXEC, 1, 1, 3, 1, 5, 0, 0);
        check("R3", "one source hit", int'(ld_o), 2);
        single(EXEC, 1, 1, 3, 0, 0, 0, 0);
        check("R7", "mark gone after one group", int'(ld_o), 2);
        check("R8", "total of three singles", int'(tot_o), 5);
    endtask

    task automatic t_pairs();
        fresh();
        issue(LOAD, 1, 0, 0, 0, 0, 0, 0, 7, 0);
        issue(LOAD, 0, 1, 0, 0, 0, 0, 0, 9, 0);
        single(EXEC, 0, 1, 7, 1, 9, 0, 0);
        check("R3", "two sources hit", int'(ld_o), 4);
        issue(LOAD, 1, 0, 0, 0, 0, 0, 0, 2, 0);
        issue(EXEC, 0, 1, 0, 1, 2, 0, 0, 0, 0);
        check("R2", "same group no stall", int'(ld_o), 4);
        single(EXEC, 0, 1, 2, 0, 0, 0, 0);
        check("R2", "next group stalls", int'(ld_o), 6);
    endtask

    task automatic t_invalid();
        fresh();
        single(LOAD, 0, 0, 0, 0, 0, 4, 0);
        single(EXEC, 0, 0, 4, 0, 4, 0, 0);
        check("R4", "invalid sources ignored", int'(ld_o), 0);
    endtask

    task automatic t_unit_src();
        fresh();
        single(LOAD, 0, 0, 0, 0, 0, 1, 0);
        single(CTI, 0, 1, 1, 1, 1, 0, 0);
        check("R5", "transfer checks A", int'(ld_o), 2);
        single(LOAD, 0, 0, 0, 0, 0, 1, 0);
        single(CTI, 0, 1, 6, 1, 1, 0, 0);
        check("R5", "transfer ignores B", int'(ld_o), 2);
        single(LOAD, 0, 0, 0, 0, 0, 1, 0);
        single(STORE, 0, 1, 1, 1, 1, 0, 0);
        check("R5", "store checks none", int'(ld_o), 2);
        single(LOAD, 0, 0, 0, 0, 0, 1, 0);
        single(LOAD, 0, 1, 1, 1, 1, 8, 0);
        check("R5", "load checks none", int'(ld_o), 2);
        single(LOAD, 0, 0, 0, 0, 0, 1, 0);
        single(CMP, 0, 1, 0, 1, 1, 0, 0);
        check("R5", "compare checks B", int'(ld_o), 4);
        check("R6", "untaken transfers", int'(ut_o), 2);
    endtask

    task automatic t_branch();
        fresh();
        single(CTI, 0, 0, 0, 0, 0, 0, 1);
        check("R6", "taken ctrl_stall", int'(cti_o), 2);
        check("R6", "taken count", int'(tk_o), 1);
        single(CTI, 0, 0, 0, 0, 0, 0, 0);
        check("R6", "untaken count", int'(ut_o), 1);
        check("R6", "untaken leaves ctrl_stall", int'(cti_o), 2);
        single(EXEC, 0, 0, 0, 0, 0, 0, 1);
        check("R6", "taken flag on execute", int'(tk_o), 1);
        check("R6", "taken flag on execute stall", int'(cti_o), 2);
    endtask

    task automatic t_total();
        fresh();
        issue(EXEC, 1, 0, 3, 0, 0, 0, 0, 0, 0);
        check("R8", "no post before last", int'(tot_o), 0);
        issue(CTI, 0, 1, 2, 0, 0, 0, 0, 0, 1);
        check("R8", "pair with taken transfer", int'(tot_o), 7);
        single(LOAD, 1, 0, 0, 0, 0, 5, 0);
        check("R8", "single load", int'(tot_o), 8);
        issue(EXEC, 1, 0, 1, 1, 5, 0, 0, 0, 0);
        issue(EXEC, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        check("R8", "pair with load-use", int'(tot_o), 12);
    endtask

    task automatic t_clr_priority();
        fresh();
        single(CTI, 3, 0, 0, 0, 0, 0, 1);
        clr = 1'b1;
        single(CTI, 5, 0, 0, 0, 0, 0, 1);
        clr = 1'b0;
        check("R1", "clear beats issue ctrl", int'(cti_o), 0);
        check("R1", "clear beats issue taken", int'(tk_o), 0);
        check("R1", "clear beats issue total", int'(tot_o), 0);
    endtask

    task automatic t_saturate();
        fresh();
        for (int i = 0; i < 130; i++) single(CTI, 0, 0, 0, 0, 0, 0, 1);
        check("R9", "ctrl_stall saturates", int'(cti_o), 255);
        check("R9", "taken below ceiling", int'(tk_o), 130);
        check("R9", "total saturates", int'(tot_o), 255);
        for (int i = 0; i < 260; i++) single(CTI, 0, 0, 0, 0, 0, 0, 0);
        check("R9", "untaken saturates", int'(ut_o), 255);
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load_use();
        t_pairs();
        t_invalid();
        t_unit_src();
        t_branch();
        t_total();
        t_clr_priority();
        t_saturate();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule